// File: doc/BRIEF.md
# Frequency Select and Test Divider

This block turns the three frequency-select strap pins and one software-owned SDRAM speed bit into the operating mode of a system clock generator. It drives a registered mode code and the rate-select codes for the downstream synthesizers. It also drives an output-enable line that is low when every clock output must float. In test mode it divides the incoming clock and sends the results out directly. One copy is divided by two for the host, memory and USB groups. One is divided by three for the hub group. One is divided by six for the PCI and interrupt-controller groups. The reference group receives the incoming clock unchanged.

The strap pins are captured on the first clock edge after reset is released and then held until the next reset. The SDRAM speed bit can be written at any time. It only takes effect when the CPU rate is set to 133 MHz. A change is applied only on the edge where the six-cycle divider pattern starts again, so none of the other clock groups sees a disturbance.

Top module: `clkgen_fsel`

## Requirements
- R1: While `rst_ni` is low: `mode_o` = 0, `oe_o` = 0, `cpu_sel_o` = 3, `sdram_sel_o` = 0, and all four test clock outputs are low.
- R2: Straps with fs[2]=0 and fs[0]=0 (fs[1] ignored) give `mode_o` = 0 (float), `oe_o` = 0 and `cpu_sel_o` = 3.
- R3: Straps with fs[2]=0 and fs[0]=1 give `mode_o` = 1 (test) and `oe_o` = 1. `tclk_div2_o` toggles on every edge. `tclk_div3_o` is high for one edge in three. `tclk_div6_o` is high for three edges in six. `tclk_ref_o` follows `clk_i`.
- R4: With fs[2]=1, fs[1:0] picks the CPU rate. 00 gives `cpu_sel_o` = 0 and `mode_o` = 2 (66/100). 01 gives `cpu_sel_o` = 1 and `mode_o` = 3 (100/100). 1x gives `cpu_sel_o` = 2 and `mode_o` = 5 (133/100), or `mode_o` = 4 (133/133) when the speed bit is set.
- R5: `sdram_sel_o` (1 = 133 MHz, 0 = 100 MHz) is 1 only when the CPU setting is 133 MHz and `sdram_fast_i` is 1. In every other mode the speed bit has no effect on any output.
- R6: A change of `sdram_fast_i` reaches `sdram_sel_o` and `mode_o` only on a pattern-restart edge. Those are edge 1 after reset release and then every sixth edge (7, 13, ...).
- R7: Straps are sampled on the first edge after reset release. Later strap changes do not affect any output until the next reset.
- R8: On the first edge after reset release, all three divided outputs go high together in test mode.
- R9: Outside test mode, the four test clock outputs are held low.
- R10: `cpu_sel_o` and `oe_o` do not change while the SDRAM speed switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the test clock that is divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 3 | Frequency-select strap pins |
| sdram_fast_i | input | 1 | SDRAM speed request from the register (1 = 133 MHz) |
| mode_o | output | 3 | Registered mode code (0 float, 1 test, 2 66/100, 3 100/100, 4 133/133, 5 133/100) |
| cpu_sel_o | output | 2 | CPU rate select (0 = 66, 1 = 100, 2 = 133, 3 = external/none) |
| sdram_sel_o | output | 1 | SDRAM rate select (1 = 133 MHz) |
| oe_o | output | 1 | Output enable; 0 puts all clock outputs in high impedance |
| tclk_div2_o | output | 1 | Test clock divided by two |
| tclk_div3_o | output | 1 | Test clock divided by three |
| tclk_div6_o | output | 1 | Test clock divided by six |
| tclk_ref_o | output | 1 | Test clock passed through |

## Verification
The assertions check four things on every cycle:
- divided outputs stay quiet outside test mode;
- the speed select only changes right after a pattern restart;
- the CPU select and enable stay frozen once the straps are latched;
- the divide-by-two output alternates, and all three dividers are high on a restart edge.

The bench scenarios are needed for the rest:
- the exact strap-to-mode mapping, including the fs[1] don't-care;
- the reset values;
- the strap pins being ignored after capture;
- the exact edge on which a mid-cycle speed request takes effect;
- the reference clock following the input in test mode.

// File: rtl/clkgen_fsel_pkg.sv
`timescale 1ns/1ps
package clkgen_fsel_pkg;

  typedef enum logic [2:0] {
    MODE_HIZ     = 3'd0,
    MODE_TEST    = 3'd1,
    MODE_66_100  = 3'd2,
    MODE_100_100 = 3'd3,
    MODE_133_133 = 3'd4,
    MODE_133_100 = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    CPU_66  = 2'd0,
    CPU_100 = 2'd1,
    CPU_133 = 2'd2,
    CPU_EXT = 2'd3
  } cpu_sel_e;

  function automatic mode_e decode_mode(input logic [2:0] fs, input logic fast);
    mode_e m;
    if (!fs[2]) begin
      m = fs[0] ? MODE_TEST : MODE_HIZ;
    end else begin
      unique case (fs[1:0])
        2'b00:   m = MODE_66_100;
        2'b01:   m = MODE_100_100;
        default: m = fast ? MODE_133_133 : MODE_133_100;
      endcase
    end
    return m;
  endfunction

  function automatic cpu_sel_e cpu_of_mode(input mode_e m);
    cpu_sel_e c;
    unique case (m)
      MODE_66_100:                c = CPU_66;
      MODE_100_100:               c = CPU_100;
      MODE_133_133, MODE_133_100: c = CPU_133;
      default:                    c = CPU_EXT;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/clkgen_fsel_strap.sv
`timescale 1ns/1ps
module clkgen_fsel_strap #(
  parameter int unsigned FS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_i,
  output logic [FS_W-1:0] fs_eff_o
);
  logic            cap_q;
  logic [FS_W-1:0] fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      fs_q  <= '0;
    end else if (!cap_q) begin
      cap_q <= 1'b1;
      fs_q  <= fs_i;
    end
  end

  // Live pins until the capture edge, latched copy afterwards
  assign fs_eff_o = cap_q ? fs_q : fs_i;
endmodule

// File: rtl/clkgen_fsel_divchain.sv
`timescale 1ns/1ps
module clkgen_fsel_divchain #(
  parameter int unsigned DIV_LO  = 2,
  parameter int unsigned DIV_MID = 3,
  parameter int unsigned DIV_HI  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] div_o,
  output logic       wrap_o,
  output logic       phase_zero_o
);
  localparam int unsigned CNT_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam int unsigned DIVS [3] = '{DIV_LO, DIV_MID, DIV_HI};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = (cnt_q == CNT_W'(DIV_HI - 1)) ? '0 : cnt_q + 1'b1;
  assign wrap_o  = (cnt_nxt == '0);
  assign phase_zero_o = (cnt_q == '0);

  // Preload last phase so the first edge after reset starts every divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(DIV_HI - 1);
    else         cnt_q <= cnt_nxt;
  end

  for (genvar g = 0; g < 3; g++) begin : g_div
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_o[g] <= 1'b0;
      else         div_o[g] <= ((32'(cnt_nxt) % DIVS[g]) < (DIVS[g] / 2));
    end
  end
endmodule

// File: rtl/clkgen_fsel_sdram_sync.sv
`timescale 1ns/1ps
module clkgen_fsel_sdram_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic fast_i,
  output logic fast_eff_o
);
  logic fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fast_q <= 1'b0;
    else if (wrap_i) fast_q <= fast_i;
  end

  // Value that the mode register takes on this edge
  assign fast_eff_o = wrap_i ? fast_i : fast_q;
endmodule

// File: rtl/clkgen_fsel.sv
`timescale 1ns/1ps
module clkgen_fsel #(
  parameter int unsigned DIV_LO  = 2,
  parameter int unsigned DIV_MID = 3,
  parameter int unsigned DIV_HI  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] fs_i,
  input  logic       sdram_fast_i,
  output logic [2:0] mode_o,
  output logic [1:0] cpu_sel_o,
  output logic       sdram_sel_o,
  output logic       oe_o,
  output logic       tclk_div2_o,
  output logic       tclk_div3_o,
  output logic       tclk_div6_o,
  output logic       tclk_ref_o
);
  import clkgen_fsel_pkg::*;

  logic [2:0] fs_eff;
  logic [2:0] div;
  logic       wrap, phase_zero, fast_eff, test_on;
  mode_e      mode_q;

  clkgen_fsel_strap #(.FS_W(3)) u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fs_i     (fs_i),
    .fs_eff_o (fs_eff)
  );

  clkgen_fsel_divchain #(
    .DIV_LO (DIV_LO),
    .DIV_MID(DIV_MID),
    .DIV_HI (DIV_HI)
  ) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .div_o        (div),
    .wrap_o       (wrap),
    .phase_zero_o (phase_zero)
  );

  clkgen_fsel_sdram_sync u_sdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap),
    .fast_i     (sdram_fast_i),
    .fast_eff_o (fast_eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_HIZ;
    else         mode_q <= decode_mode(fs_eff, fast_eff);
  end

  assign test_on     = (mode_q == MODE_TEST);
  assign mode_o      = mode_q;
  assign cpu_sel_o   = cpu_of_mode(mode_q);
  assign sdram_sel_o = (mode_q == MODE_133_133);
  assign oe_o        = (mode_q != MODE_HIZ);
  assign tclk_div2_o = test_on & div[0];
  assign tclk_div3_o = test_on & div[1];
  assign tclk_div6_o = test_on & div[2];
  assign tclk_ref_o  = test_on & clk_i;
endmodule

// File: rtl/clkgen_fsel_chk.sv
`timescale 1ns/1ps
module clkgen_fsel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic [1:0] cpu_sel_i,
  input logic       sdram_sel_i,
  input logic       oe_i,
  input logic       div2_i,
  input logic       div3_i,
  input logic       div6_i,
  input logic       phase_zero_i
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= 2'd0;
    else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
  end

  AST_NONTEST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'd1) |-> (!div2_i && !div3_i && !div6_i)); // R9

  AST_SDR_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdram_sel_i) |-> phase_zero_i); // R6

  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> ($stable(cpu_sel_i) && $stable(oe_i))); // R7

  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && mode_i == 3'd1) |-> (div2_i != $past(div2_i))); // R3

  AST_DIV_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && phase_zero_i) |-> (div2_i && div3_i && div6_i)); // R8
endmodule

bind clkgen_fsel clkgen_fsel_chk u_fsel_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_o),
  .cpu_sel_i    (cpu_sel_o),
  .sdram_sel_i  (sdram_sel_o),
  .oe_i         (oe_o),
  .div2_i       (tclk_div2_o),
  .div3_i       (tclk_div3_o),
  .div6_i       (tclk_div6_o),
  .phase_zero_i (phase_zero)
);

// File: tb/tb_clkgen_fsel.sv
`timescale 1ns/1ps
module tb_clkgen_fsel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] fs_i = 3'b000;
  logic       sdram_fast_i = 1'b0;
  logic [2:0] mode_o;
  logic [1:0] cpu_sel_o;
  logic       sdram_sel_o, oe_o;
  logic       tclk_div2_o, tclk_div3_o, tclk_div6_o, tclk_ref_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  clkgen_fsel dut (
    .clk_i, .rst_ni, .fs_i, .sdram_fast_i, .mode_o, .cpu_sel_o,
    .sdram_sel_o, .oe_o, .tclk_div2_o, .tclk_div3_o, .tclk_div6_o, .tclk_ref_o
  );

  typedef struct packed {
    logic [2:0] fs;
    logic       fast;
    logic [2:0] mode;
    logic [1:0] cpu;
    logic       sdr;
    logic       oe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 3'd0, 2'd3, 1'b0, 1'b0},  // R2
    '{3'b010, 1'b1, 3'd0, 2'd3, 1'b0, 1'b0},  // R2 fs1 ignored
    '{3'b001, 1'b0, 3'd1, 2'd3, 1'b0, 1'b1},  // R3
    '{3'b011, 1'b1, 3'd1, 2'd3, 1'b0, 1'b1},  // R3 / R5
    '{3'b100, 1'b0, 3'd2, 2'd0, 1'b0, 1'b1},  // R4
    '{3'b100, 1'b1, 3'd2, 2'd0, 1'b0, 1'b1},  // R5
    '{3'b101, 1'b0, 3'd3, 2'd1, 1'b0, 1'b1},  // R4
    '{3'b101, 1'b1, 3'd3, 2'd1, 1'b0, 1'b1},  // R5
    '{3'b110, 1'b0, 3'd5, 2'd2, 1'b0, 1'b1},  // R4
    '{3'b110, 1'b1, 3'd4, 2'd2, 1'b1, 1'b1},  // R4 / R5
    '{3'b111, 1'b0, 3'd5, 2'd2, 1'b0, 1'b1},  // R4
    '{3'b111, 1'b1, 3'd4, 2'd2, 1'b1, 1'b1}   // R5
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic start(input logic [2:0] fs, input logic fast);
    @(negedge clk_i);
    rst_ni = 1'b0;
    fs_i = fs;
    sdram_fast_i = fast;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    fs_i = 3'b001;
    repeat (2) @(negedge clk_i);
    #2;
    chk("R1 mode", mode_o, 0);
    chk("R1 oe", oe_o, 0);
    chk("R1 cpu", cpu_sel_o, 3);
    chk("R1 sdr", sdram_sel_o, 0);
    chk("R1 tclk", {tclk_div2_o, tclk_div3_o, tclk_div6_o, tclk_ref_o}, 0);

    // Vector table: R2 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      start(VECS[i].fs, VECS[i].fast);
      repeat (7) tick();
      chk("R4 mode", mode_o, VECS[i].mode);
      chk("R4 cpu", cpu_sel_o, VECS[i].cpu);
      chk("R5 sdr", sdram_sel_o, VECS[i].sdr);
      chk("R2 oe", oe_o, VECS[i].oe);
      if (VECS[i].mode != 3'd1)
        chk("R9 tclk", {tclk_div2_o, tclk_div3_o, tclk_div6_o}, 0);
    end

    // Test mode waveforms: R3 R8
    start(3'b001, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      tick();
      chk("R3 div2", tclk_div2_o, ((k - 1) % 2) == 0);
      chk("R3 div3", tclk_div3_o, ((k - 1) % 3) == 0);
      chk("R3 div6", tclk_div6_o, ((k - 1) % 6) < 3);
      if (k == 1) chk("R8 in phase", {tclk_div2_o, tclk_div3_o, tclk_div6_o}, 7);
      chk("R3 ref high", tclk_ref_o, 1);
      @(negedge clk_i);
      #5;
      chk("R3 ref low", tclk_ref_o, 0);
    end

    // Straps ignored after capture: R7
    start(3'b101, 1'b0);
    tick();
    fs_i = 3'b001;
    repeat (4) tick();
    chk("R7 mode", mode_o, 3);
    fs_i = 3'b000;
    repeat (4) tick();
    chk("R7 mode", mode_o, 3);
    chk("R7 oe", oe_o, 1);
    chk("R9 tclk", {tclk_div2_o, tclk_div3_o, tclk_div6_o, tclk_ref_o}, 0);

    // Speed bit at 66 MHz has no effect: R5
    start(3'b100, 1'b0);
    tick();
    sdram_fast_i = 1'b1;
    repeat (13) tick();
    chk("R5 sdr", sdram_sel_o, 0);
    chk("R5 mode", mode_o, 2);

    // Boundary-aligned switch: R6 R10
    start(3'b110, 1'b0);
    for (int k = 1; k <= 20; k++) begin
      tick();
      if (k == 8) sdram_fast_i = 1'b1;
      if (k == 14) sdram_fast_i = 1'b0;
      if (k >= 9 && k <= 12) chk("R6 hold", sdram_sel_o, 0);
      if (k >= 13 && k <= 18) chk("R6 switch", sdram_sel_o, 1);
      if (k == 13) chk("R6 mode", mode_o, 4);
      if (k >= 19) chk("R6 back", sdram_sel_o, 0);
      chk("R10 cpu", cpu_sel_o, 2);
      chk("R10 oe", oe_o, 1);
    end

    summary();
  end
endmodule